// File: doc/BRIEF.md
# I2C Target Controller with External Bus Release

This block is a 7-bit-address I2C target that sits on a microcontroller peripheral bus. It watches the synchronized SCL and SDA lines for START, STOP and repeated START, compares the first byte against a programmable own address, and then either receives bytes from the master or sends bytes to it. Both lines are open-drain: the block only ever pulls them low, through `scl_oe` and `sda_oe`. Received bytes leave on a valid/ready stream. Bytes to send arrive on a second valid/ready stream.

The receive stream holds `rx_valid` and `rx_data` steady until the consumer raises `rx_ready`. A byte is taken on a clock edge where both are high. While the previous byte is still unread, a new one cannot be stored. If clock stretching is off, that new byte is NACKed and dropped. If clock stretching is on, the target holds SCL low after the ACK clock until the byte has been taken.

The transmit stream is driven by the producer. It holds `tx_valid` and `tx_data` until it sees `tx_ready` high at a clock edge. `tx_ready` rises only when the engine needs a byte. If no byte is offered at that moment, the engine stretches SCL when stretching is enabled, and otherwise sends 0xFF.

Software controls the block through three byte registers. An active-low release input, once qualified by a minimum low time, aborts any transfer, floats both lines and raises a sticky flag that drives `irq`. This does not touch the configuration. A soft-reset bit holds the engine idle and clears the other control bits.

Top module: `i2c_target_ctrl`

## Requirements
- R1: After `rst_n` is deasserted, `scl_oe`, `sda_oe`, `rx_valid` and `irq` are 0. The control register (offset 0), the status register (offset 1) and the address register (offset 2) all read 0x00.
- R2: A master write whose first byte is {address register bits [6:0], R/W=0} is ACKed (SDA low on the 9th clock). Each following data byte, MSB first, is ACKed and appears on the receive stream in arrival order.
- R3: If the first byte after a START does not match the address register, SDA stays high on the 9th clock. No byte is delivered, and the bus is ignored until the next START or STOP.
- R4: After an ACKed address with R/W=1, each byte taken from the transmit stream is shifted out MSB first. SDA changes only while SCL is low. A master ACK fetches the next byte and a master NACK ends the transfer. With no byte offered and stretching off, 0xFF is sent.
- R5: With control bit 2 at 0, a data byte that completes while `rx_valid` is still high is NACKed and discarded. The held byte stays on `rx_data` unchanged.
- R6: With control bit 2 at 1, SCL is held low after the ACK clock of a byte, for as long as the received byte is unread or no transmit byte is offered. SCL is released once the stream is ready. Stretching never starts with bit 2 at 0.
- R7: With control bit 1 at 1, `bfr_n` low for at least 5 consecutive clock cycles, seen after a two-flop synchronizer, sets status bit 0 once per low period. Shorter pulses, or any pulse while bit 1 is 0, leave it at 0. `irq` equals status bit 0.
- R8: A qualified release request returns the engine to idle with `scl_oe` and `sda_oe` at 0 and any unread received byte dropped. The control and address registers keep their values.
- R9: Writing status with bit 0 = 1 clears the flag, and writing 0 there has no effect. A qualifying request in the same cycle as a clearing write leaves the flag set.
- R10: While control bit 0 is 1, the engine is held idle with both line enables at 0, and control bits 1 and 2 are forced to 0. The address register is kept. Writing bit 0 = 0 releases the engine with no wait needed.
- R11: A repeated START at any point restarts address reception, so a target that ignored a mismatched address responds to a matching address sent after the repeated START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 own address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from `reg_addr`) |
| irq | output | 1 | High while the release-request flag is set |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | 8 | Received byte |
| tx_valid | input | 1 | Producer offers a byte to send |
| tx_ready | output | 1 | Engine takes the offered byte |
| tx_data | input | 8 | Byte to send |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| bfr_n | input | 1 | Active-low bus release request |

## Verification
Several properties are checked on every cycle. A qualified release request or a held soft reset always floats both lines on the next cycle. A qualified request fires only once per low period and never without the request low in the cycle before. A stretch only starts when stretching was enabled. An unread received byte never changes. Transmitted SDA never moves while SCL is high. The enable bits stay cleared while soft reset is held.

Other behaviours need the bench's open-drain master driving whole transactions:
- address match and mismatch;
- byte order on both streams;
- the NACK on overrun;
- the 0xFF fill;
- repeated START;
- the exact 4-versus-5-cycle qualification boundary;
- register preservation across an abort.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int I2C_DW = 8;
  localparam int I2C_AW = I2C_DW - 1;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_STAT = 2'd1;
  localparam logic [1:0] RA_ADDR = 2'd2;

  localparam int CB_SRST  = 0;
  localparam int CB_BFREN = 1;
  localparam int CB_STREN = 2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RACK, ST_RWAIT,
    ST_TX, ST_TACK, ST_TWAIT, ST_SKIP
  } eng_state_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] ff;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= '1;
      else        ff <= {ff[STAGES-2:0], d[i]};
    end
    assign q[i] = ff[STAGES-1];
  end
endmodule

// File: rtl/i2c_tgt_bfr.sv
module i2c_tgt_bfr #(
  parameter int MIN_LOW = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic req_n_s,
  output logic hit
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] SAT  = CW'(MIN_LOW);
  localparam logic [CW-1:0] FIRE = CW'(MIN_LOW - 1);

  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run <= '0;
    else if (!en || req_n_s)   run <= '0;
    else if (run != SAT)       run <= run + 1'b1;
  end

  assign hit = en && !req_n_s && (run == FIRE);

  assert_bfr_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);
  assert_bfr_low_before_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> !$past(req_n_s));
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs import i2c_tgt_pkg::*; #(
  parameter logic [I2C_AW-1:0] DEF_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [7:0]        wdata,
  input  logic              bfr_hit,
  output logic [7:0]        rdata,
  output logic              srst,
  output logic              bfr_en,
  output logic              str_en,
  output logic [I2C_AW-1:0] own_addr,
  output logic              flag
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en && (addr == RA_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst     <= 1'b0;
      bfr_en   <= 1'b0;
      str_en   <= 1'b0;
      own_addr <= DEF_ADDR;
      flag     <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        srst   <= wdata[CB_SRST];
        bfr_en <= wdata[CB_SRST] ? 1'b0 : wdata[CB_BFREN];
        str_en <= wdata[CB_SRST] ? 1'b0 : wdata[CB_STREN];
      end else if (srst) begin
        bfr_en <= 1'b0;
        str_en <= 1'b0;
      end
      if (wr_en && addr == RA_ADDR) own_addr <= wdata[I2C_AW-1:0];
      if (bfr_hit)                                   flag <= 1'b1;
      else if (wr_en && addr == RA_STAT && wdata[0]) flag <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      RA_CTRL: rdata = {5'b0, str_en, bfr_en, srst};
      RA_STAT: rdata = {7'b0, flag};
      RA_ADDR: rdata = {{(8-I2C_AW){1'b0}}, own_addr};
      default: rdata = 8'h00;
    endcase
  end

  assert_srst_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (srst && !ctrl_wr) |=> (!bfr_en && !str_en));
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine import i2c_tgt_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              str_en,
  input  logic [I2C_AW-1:0] own_addr,
  input  logic              scl_s,
  input  logic              sda_s,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [I2C_DW-1:0] rx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [I2C_DW-1:0] tx_data
);
  localparam int CW = $clog2(I2C_DW);
  localparam logic [CW-1:0] LAST = CW'(I2C_DW - 1);

  eng_state_t        st;
  logic [CW-1:0]     cnt;
  logic [I2C_DW-1:0] sh;
  logic              scl_q, sda_q, rw, mack, got8;
  logic              start_c, stop_c, rise, fall, evt, want_tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign start_c = scl_s && scl_q && sda_q && !sda_s;
  assign stop_c  = scl_s && scl_q && !sda_q && sda_s;
  assign rise    = scl_s && !scl_q;
  assign fall    = !scl_s && scl_q;
  assign evt     = clr || start_c || stop_c;
  assign want_tx = !evt && fall && ((st == ST_AACK && rw) || (st == ST_TACK && mack));
  assign tx_ready = want_tx || (!evt && st == ST_TWAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; rw <= 1'b0; mack <= 1'b0; got8 <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0; rx_valid <= 1'b0; rx_data <= '0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (clr) begin
        st <= ST_IDLE; cnt <= '0; got8 <= 1'b0;
        scl_oe <= 1'b0; sda_oe <= 1'b0; rx_valid <= 1'b0;
      end else if (start_c) begin
        st <= ST_ADDR; cnt <= '0; got8 <= 1'b0; scl_oe <= 1'b0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        st <= ST_IDLE; scl_oe <= 1'b0; sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_RX: begin
            if (rise) begin
              sh  <= {sh[I2C_DW-2:0], sda_s};
              cnt <= cnt + 1'b1;
              if (cnt == LAST) got8 <= 1'b1;
            end else if (fall && got8) begin
              got8 <= 1'b0;
              if (st == ST_ADDR) begin
                if (sh[I2C_DW-1:1] == own_addr) begin
                  st <= ST_AACK; rw <= sh[0]; sda_oe <= 1'b1;
                end else begin
                  st <= ST_SKIP;
                end
              end else begin
                st <= ST_RACK;
                if (!rx_valid) begin
                  rx_data <= sh; rx_valid <= 1'b1; sda_oe <= 1'b1;
                end
              end
            end
          end
          ST_AACK: if (fall) begin
            sda_oe <= 1'b0;
            if (!rw) st <= ST_RX;
          end
          ST_RACK: if (fall) begin
            sda_oe <= 1'b0;
            if (str_en && rx_valid && !rx_ready) begin
              scl_oe <= 1'b1; st <= ST_RWAIT;
            end else begin
              st <= ST_RX;
            end
          end
          ST_RWAIT: if (!rx_valid) begin
            scl_oe <= 1'b0; st <= ST_RX;
          end
          ST_TX: if (fall) begin
            if (cnt == LAST) begin
              sda_oe <= 1'b0; cnt <= '0; st <= ST_TACK;
            end else begin
              sda_oe <= !sh[I2C_DW-2];
              sh     <= {sh[I2C_DW-2:0], 1'b1};
              cnt    <= cnt + 1'b1;
            end
          end
          ST_TACK: begin
            if (rise) mack <= !sda_s;
            if (fall && !mack) st <= ST_SKIP;
          end
          default: ;
        endcase
        if (tx_ready) begin
          if (tx_valid) begin
            sh <= tx_data; sda_oe <= !tx_data[I2C_DW-1]; cnt <= '0;
            scl_oe <= 1'b0; st <= ST_TX;
          end else if (st != ST_TWAIT) begin
            if (str_en) begin
              scl_oe <= 1'b1; st <= ST_TWAIT;
            end else begin
              sh <= '1; sda_oe <= 1'b0; cnt <= '0; st <= ST_TX;
            end
          end
        end
      end
    end
  end

  // R8 and R10: an abort or a held soft reset floats both lines on the next cycle
  assert_clr_floats_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!scl_oe && !sda_oe));
  assert_stretch_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> $past(str_en));
  assert_rx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !clr) |=> (rx_valid && $stable(rx_data)));
  assert_tx_sda_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TX && !evt && scl_s && scl_q) |=> $stable(sda_oe));
endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl import i2c_tgt_pkg::*; #(
  parameter logic [I2C_AW-1:0] DEF_ADDR    = '0,
  parameter int                MIN_LOW     = 5,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [I2C_DW-1:0] rx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [I2C_DW-1:0] tx_data,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              bfr_n
);
  logic [2:0]        sync_q;
  logic              srst, bfr_en, str_en, flag, bfr_hit;
  logic [I2C_AW-1:0] own_addr;

  i2c_tgt_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({bfr_n, scl_i, sda_i}), .q(sync_q));

  i2c_tgt_bfr #(.MIN_LOW(MIN_LOW)) u_bfr (
    .clk(clk), .rst_n(rst_n), .en(bfr_en), .req_n_s(sync_q[2]), .hit(bfr_hit));

  i2c_tgt_regs #(.DEF_ADDR(DEF_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
    .bfr_hit(bfr_hit), .rdata(reg_rdata), .srst(srst), .bfr_en(bfr_en),
    .str_en(str_en), .own_addr(own_addr), .flag(flag));

  i2c_tgt_engine u_eng (
    .clk(clk), .rst_n(rst_n), .clr(srst || bfr_hit), .str_en(str_en),
    .own_addr(own_addr), .scl_s(sync_q[1]), .sda_s(sync_q[0]),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data));

  assign irq = flag;
endmodule

// File: tb/i2c_target_ctrl_tb_top.sv
module i2c_target_ctrl_tb_top;
  localparam int Q = 10;
  localparam int MINL = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic irq, rx_valid, tx_ready, scl_oe, sda_oe;
  logic rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic bfr_n = 1'b1;
  logic m_scl_lo = 1'b0, m_sda_lo = 1'b0;
  logic scl_bus, sda_bus;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] got[$];
  logic [7:0] tx_q[$];
  bit tx_take = 1'b0;

  always #5 clk = ~clk;

  assign scl_bus = ~(m_scl_lo | scl_oe);
  assign sda_bus = ~(m_sda_lo | sda_oe);

  i2c_target_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .scl_i(scl_bus), .sda_i(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe), .bfr_n(bfr_n));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural model of the release flag and the soft-reset hold, checked every clock
  logic bq[$];
  int   m_run = 0;
  bit   m_flag = 0, m_en = 0, m_srst = 0, m_srst_d = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      bq.delete(); m_run = 0; m_flag = 0; m_en = 0; m_srst = 0; m_srst_d = 0;
    end else begin
      bit smp, hit;
      smp = (bq.size() >= 2) ? bq[bq.size()-2] : 1'b1;
      bq.push_back(bfr_n);
      if (bq.size() > 3) void'(bq.pop_front());
      hit = m_en && !smp && (m_run == MINL - 1);
      if (!m_en || smp) m_run = 0; else if (m_run < MINL) m_run++;
      if (hit) m_flag = 1;
      else if (reg_wr_en && reg_addr == 2'd1 && reg_wdata[0]) m_flag = 0;
      m_srst_d = m_srst;
      if (reg_wr_en && reg_addr == 2'd0) begin
        m_srst = reg_wdata[0];
        m_en = reg_wdata[0] ? 1'b0 : reg_wdata[1];
      end else if (m_srst) m_en = 0;
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R7", "irq vs model flag (R9)", irq, m_flag);
      if (m_srst_d) begin
        chk("R10", "scl_oe in soft reset", scl_oe, 0);
        chk("R10", "sda_oe in soft reset", sda_oe, 0);
      end
    end
  end

  // Receive consumer and transmit producer, evaluated between edges
  always @(negedge clk) begin
    #1;
    if (rx_valid && rx_ready) got.push_back(rx_data);
    if (tx_take) void'(tx_q.pop_front());
    tx_valid = (tx_q.size() > 0);
    tx_data  = tx_valid ? tx_q[0] : 8'h00;
    tx_take  = tx_valid && tx_ready;
  end

  task automatic wq(input int n = Q);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask
  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask
  task automatic scl_up();
    m_scl_lo = 1'b0;
    @(negedge clk);
    while (!scl_bus) @(negedge clk);
  endtask
  task automatic m_start();
    m_sda_lo = 1'b0; scl_up(); wq();
    m_sda_lo = 1'b1; wq(); m_scl_lo = 1'b1; wq();
  endtask
  task automatic m_rstart();
    m_sda_lo = 1'b0; wq(); scl_up(); wq();
    m_sda_lo = 1'b1; wq(); m_scl_lo = 1'b1; wq();
  endtask
  task automatic m_stop();
    m_sda_lo = 1'b1; wq(); scl_up(); wq(); m_sda_lo = 1'b0; wq();
  endtask
  task automatic bit_w(input logic b);
    m_sda_lo = !b; wq(); scl_up(); wq(2*Q); m_scl_lo = 1'b1; wq();
  endtask
  task automatic bit_r(output logic b);
    m_sda_lo = 1'b0; wq(); scl_up(); wq(); b = sda_bus; wq(); m_scl_lo = 1'b1; wq();
  endtask
  task automatic byte_w(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_w(d[i]);
    bit_r(b); ack = !b;
  endtask
  task automatic byte_r(output logic [7:0] d, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_r(b); d[i] = b; end
    bit_w(!ack);
  endtask
  task automatic pulse_bfr(input int n);
    @(negedge clk); bfr_n = 1'b0; repeat (n) @(negedge clk); bfr_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1; n_tests++; n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic a;
    wq(4); rst_n = 1'b1; wq(4);

    // R1 reset state
    chk("R1", "scl_oe", scl_oe, 0); chk("R1", "sda_oe", sda_oe, 0);
    chk("R1", "rx_valid", rx_valid, 0); chk("R1", "irq", irq, 0);
    rd_reg(2'd0, v); chk("R1", "ctrl", v, 8'h00);
    rd_reg(2'd1, v); chk("R1", "status", v, 8'h00);
    rd_reg(2'd2, v); chk("R1", "address", v, 8'h00);

    wr_reg(2'd2, 8'h42);
    rx_ready = 1'b1;

    // R2 write with ACK
    m_start(); byte_w(8'h84, a); chk("R2", "address ack", a, 1);
    byte_w(8'hA5, a); chk("R2", "byte0 ack", a, 1);
    byte_w(8'h3C, a); chk("R2", "byte1 ack", a, 1);
    m_stop(); wq();
    chk("R2", "rx count", got.size(), 2);
    if (got.size() == 2) begin
      chk("R2", "rx byte0", got[0], 8'hA5);
      chk("R2", "rx byte1", got[1], 8'h3C);
    end
    got.delete();

    // R3 mismatch
    m_start(); byte_w(8'h86, a); chk("R3", "mismatch no ack", a, 0);
    byte_w(8'h77, a); chk("R3", "ignored byte no ack", a, 0);
    m_stop(); wq(); chk("R3", "no rx bytes", got.size(), 0);

    // R11 repeated start after mismatch
    m_start(); byte_w(8'h86, a); chk("R11", "first address ignored", a, 0);
    m_rstart(); byte_w(8'h84, a); chk("R11", "address after rstart ack", a, 1);
    byte_w(8'h99, a); chk("R11", "byte ack", a, 1);
    m_stop(); wq();
    chk("R11", "rx count", got.size(), 1);
    if (got.size() == 1) chk("R11", "rx byte", got[0], 8'h99);
    got.delete();

    // R4 read with ACK then NACK
    tx_q.push_back(8'h5A); tx_q.push_back(8'hC3);
    m_start(); byte_w(8'h85, a); chk("R4", "read address ack", a, 1);
    byte_r(v, 1'b1); chk("R4", "read byte0", v, 8'h5A);
    byte_r(v, 1'b0); chk("R4", "read byte1", v, 8'hC3);
    m_stop(); wq(); chk("R4", "tx queue drained", tx_q.size(), 0);
    m_start(); byte_w(8'h85, a); byte_r(v, 1'b0); chk("R4", "empty fill", v, 8'hFF);
    m_stop(); wq();

    // R5 overrun without stretch
    rx_ready = 1'b0;
    m_start(); byte_w(8'h84, a);
    byte_w(8'h44, a); chk("R5", "first byte ack", a, 1);
    byte_w(8'h55, a); chk("R5", "overrun nack", a, 0);
    m_stop(); wq();
    chk("R5", "held valid", rx_valid, 1); chk("R5", "held data", rx_data, 8'h44);
    rx_ready = 1'b1; wq(4);
    chk("R5", "only first byte", got.size(), 1);
    got.delete();

    // R6 stretch on receive
    wr_reg(2'd0, 8'h04); rx_ready = 1'b0;
    m_start(); byte_w(8'h84, a);
    byte_w(8'h11, a); chk("R6", "byte ack", a, 1);
    wq(20);
    chk("R6", "scl held", scl_oe, 1); chk("R6", "rx data held", rx_data, 8'h11);
    rx_ready = 1'b1; wq(6);
    chk("R6", "scl released", scl_oe, 0);
    byte_w(8'h22, a); chk("R6", "second byte ack", a, 1);
    m_stop(); wq();
    chk("R6", "rx count", got.size(), 2);
    got.delete();

    // R7 R8 release request during a stretch
    wr_reg(2'd0, 8'h06); rx_ready = 1'b0;
    m_start(); byte_w(8'h84, a); byte_w(8'h33, a); wq(10);
    pulse_bfr(MINL - 1); wq(10);
    chk("R7", "short pulse no flag", irq, 0); chk("R7", "short pulse keeps stretch", scl_oe, 1);
    pulse_bfr(MINL); wq(10);
    chk("R7", "qualified pulse flag", irq, 1);
    chk("R8", "scl floated", scl_oe, 0); chk("R8", "sda floated", sda_oe, 0);
    chk("R8", "rx dropped", rx_valid, 0);
    rd_reg(2'd0, v); chk("R8", "ctrl kept", v, 8'h06);
    rd_reg(2'd2, v); chk("R8", "address kept", v, 8'h42);
    m_stop(); wq();
    // R9 clear
    wr_reg(2'd1, 8'h00); rd_reg(2'd1, v); chk("R9", "write 0 keeps flag", v, 8'h01);
    wr_reg(2'd1, 8'h01); rd_reg(2'd1, v); chk("R9", "write 1 clears flag", v, 8'h00);
    chk("R9", "irq low", irq, 0);
    // R7 disabled
    wr_reg(2'd0, 8'h00); pulse_bfr(12); wq(6);
    chk("R7", "disabled no flag", irq, 0);

    // R10 soft reset during stretch
    wr_reg(2'd0, 8'h04); rx_ready = 1'b0;
    m_start(); byte_w(8'h84, a); byte_w(8'h66, a); wq(10);
    chk("R10", "stretch before reset", scl_oe, 1);
    wr_reg(2'd0, 8'h07); wq(3);
    rd_reg(2'd0, v); chk("R10", "ctrl under reset", v, 8'h01);
    chk("R10", "scl released", scl_oe, 0); chk("R10", "rx dropped", rx_valid, 0);
    m_stop();
    wr_reg(2'd0, 8'h00);
    rd_reg(2'd2, v); chk("R10", "address kept", v, 8'h42);
    rx_ready = 1'b1;
    m_start(); byte_w(8'h84, a); chk("R10", "works after release", a, 1);
    byte_w(8'hE7, a); m_stop(); wq();
    chk("R10", "rx count after release", got.size(), 1);
    if (got.size() == 1) chk("R10", "rx byte after release", got[0], 8'hE7);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule